// File: doc/BRIEF.md
# BCD Calendar Clock Core

This core keeps wall-clock time and date in the manner of a classic PC real-time clock: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A host reaches every register through two write strobes. One loads an index and the other writes the indexed register. The indexed register always appears on a read-data output. A 32.768 kHz enable pulse drives a prescaler, and the time advances by one second every `DIV` such pulses. The advance carries through minutes, hours, days, months and years. Month lengths follow the calendar, and February gets a leap day whenever the two-digit year is a multiple of four.

The host chooses how values are presented. Values can be BCD or binary, and hours can be 12-hour or 24-hour, with PM carried in the top bit of the hour register. Time is stored internally as binary 24-hour values, so the same stored time reads correctly in any mode. Writes are decoded according to the mode that is active when the write happens. A status flag rises a fixed number of input pulses before each advance and stays high a fixed number afterwards, which gives the host a window in which reading is unsafe. A freeze bit suppresses both the advances and the flag while the host loads a new time. A power-valid flag drops when the power-good input goes low and stays low until the next reset.

Top module: `cal_clock_core`

## Requirements
- R1: After reset the time is 00:00:00, weekday 1, day 1, month 1, year 0, and the control register reads 0x00 (BCD, 12-hour, not frozen). In that mode the hour reads 0x12. Register 10 reads 0x00 and register 13 reads 0x80.
- R2: An index write takes the address from wdata[6:0] and ignores wdata[7]. The map is: seconds 0, minutes 2, hours 4, weekday 6, day of month 7, month 8, year 9, status 10, control 11, power status 13. Any other address reads 0x00.
- R3: Control bit 2 selects binary values when set and BCD values (tens digit in bits 7:4) when clear. The selection applies to both reads and writes of all seven time registers.
- R4: Control bit 1 selects 24-hour mode (hour 0-23) when set. When it is clear the mode is 12-hour: the hour is 1-12 and bit 7 marks PM, so midnight is 12 without PM and noon is 12 with PM.
- R5: Each update adds one second. Seconds 59 wrap to 0 and carry into minutes, minutes 59 carry into hours, and hour 23 carries into the date.
- R6: Day of month wraps to 1 after 30 in months 4, 6, 9 and 11, and after 31 in the other months. In February it wraps after 29 when the year is divisible by 4 and after 28 otherwise.
- R7: At midnight the weekday goes from 7 to 1. Month 12 wraps to 1 and carries into the year, and year 99 wraps to 0.
- R8: Register 10 bit 7 is high from LEAD input pulses before an update until HOLD pulses after it. Host writes to register 10 are ignored.
- R9: While control bit 7 is set, no update changes the time and the status flag stays low. Once the bit is cleared, updates resume.
- R10: A time register written while not frozen is accepted, and the next update starts from the written value.
- R11: Register 13 bit 7 goes to 0 after pwr_ok is sampled low and stays 0 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable pulse at the 32.768 kHz time base |
| pwr_ok | input | 1 | Clock power good; low clears the power-valid flag |
| idx_we | input | 1 | Load the register index from wdata |
| dat_we | input | 1 | Write wdata into the indexed register |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Contents of the indexed register, formatted per control mode |

## Verification
Any faulty internal state shows up at rdata as soon as the host next reads the affected register. A wrong carry term shows up one update after the boundary it mishandles, for example at a month end, a leap February or a year wrap. A wrong format path is visible as soon as a value is written in one mode and read back in another. A prescaler phase error moves the edges of the status flag relative to the seconds change, and that is visible within one second's worth of input pulses.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int IDX_W   = 7;
  localparam int FIELD_N = 7;

  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_time_t;

  typedef enum int {F_SEC = 0, F_MIN = 1, F_HR = 2, F_WDAY = 3,
                    F_MDAY = 4, F_MON = 5, F_YR = 6} field_e;

  localparam logic [IDX_W-1:0] A_SEC  = 7'd0;
  localparam logic [IDX_W-1:0] A_MIN  = 7'd2;
  localparam logic [IDX_W-1:0] A_HR   = 7'd4;
  localparam logic [IDX_W-1:0] A_WDAY = 7'd6;
  localparam logic [IDX_W-1:0] A_MDAY = 7'd7;
  localparam logic [IDX_W-1:0] A_MON  = 7'd8;
  localparam logic [IDX_W-1:0] A_YR   = 7'd9;
  localparam logic [IDX_W-1:0] A_STAT = 7'd10;
  localparam logic [IDX_W-1:0] A_CTRL = 7'd11;
  localparam logic [IDX_W-1:0] A_PWR  = 7'd13;

  localparam logic [IDX_W-1:0] FIELD_ADDR [FIELD_N] =
    '{A_SEC, A_MIN, A_HR, A_WDAY, A_MDAY, A_MON, A_YR};

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      4'd2:                    return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      default:                 return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int DIV  = 32768,
  parameter int LEAD = 8,
  parameter int HOLD = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic freeze,
  output logic adv,
  output logic uip
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_UIP  = PH_W'(DIV - LEAD);
  localparam logic [PH_W-1:0] PH_HOLD = PH_W'(HOLD);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            ran_q, ran_d;
  logic            wrap;

  always_comb begin
    wrap  = tick && (ph_q == PH_LAST);
    ph_d  = wrap ? '0 : ph_q + 1'b1;
    adv   = wrap && !freeze;
    ran_d = ran_q | adv;
    uip   = !freeze && ((ph_q >= PH_UIP) || (ran_q && (ph_q < PH_HOLD)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      ran_q <= 1'b0;
    end else if (tick) begin
      ph_q  <= ph_d;
      ran_q <= ran_d;
    end
  end

endmodule

// File: rtl/cal_time_regs.sv
module cal_time_regs
  import cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic [FIELD_N-1:0] ld_sel,
  input  logic [7:0]         ld_val,
  output cal_time_t          cur
);
  cal_time_t cur_q, nxt;
  logic      en;

  always_comb begin
    nxt = cur_q;
    if (adv) begin
      if (nxt.sec >= 6'd59) begin
        nxt.sec = 6'd0;
        if (nxt.min >= 6'd59) begin
          nxt.min = 6'd0;
          if (nxt.hr >= 5'd23) begin
            nxt.hr   = 5'd0;
            nxt.wday = (nxt.wday >= 3'd7 || nxt.wday == 3'd0) ? 3'd1 : nxt.wday + 3'd1;
            if (nxt.mday >= month_len(nxt.mon, nxt.yr)) begin
              nxt.mday = 5'd1;
              if (nxt.mon >= 4'd12) begin
                nxt.mon = 4'd1;
                nxt.yr  = (nxt.yr >= 7'd99) ? 7'd0 : nxt.yr + 7'd1;
              end else begin
                nxt.mon = nxt.mon + 4'd1;
              end
            end else begin
              nxt.mday = nxt.mday + 5'd1;
            end
          end else begin
            nxt.hr = nxt.hr + 5'd1;
          end
        end else begin
          nxt.min = nxt.min + 6'd1;
        end
      end else begin
        nxt.sec = nxt.sec + 6'd1;
      end
    end
    // host loads take precedence over the update on the same field
    if (ld_sel[F_SEC])  nxt.sec  = ld_val[5:0];
    if (ld_sel[F_MIN])  nxt.min  = ld_val[5:0];
    if (ld_sel[F_HR])   nxt.hr   = ld_val[4:0];
    if (ld_sel[F_WDAY]) nxt.wday = ld_val[2:0];
    if (ld_sel[F_MDAY]) nxt.mday = ld_val[4:0];
    if (ld_sel[F_MON])  nxt.mon  = ld_val[3:0];
    if (ld_sel[F_YR])   nxt.yr   = ld_val[6:0];
    en = adv || (|ld_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q.sec  <= 6'd0;
      cur_q.min  <= 6'd0;
      cur_q.hr   <= 5'd0;
      cur_q.wday <= 3'd1;
      cur_q.mday <= 5'd1;
      cur_q.mon  <= 4'd1;
      cur_q.yr   <= 7'd0;
    end else if (en) begin
      cur_q <= nxt;
    end
  end

  assign cur = cur_q;

endmodule

// File: rtl/cal_host_port.sv
module cal_host_port
  import cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_we,
  input  logic               dat_we,
  input  logic [7:0]         wdata,
  input  cal_time_t          cur,
  input  logic               uip,
  input  logic               vrt,
  output logic [7:0]         rdata,
  output logic               freeze,
  output logic [FIELD_N-1:0] ld_sel,
  output logic [7:0]         ld_val
);
  logic [IDX_W-1:0]   idx_q;
  logic               frz_q, bin_q, h24_q;
  logic [FIELD_N-1:0] hit;
  logic               hr12_sel;
  logic [7:0]         dec_in, dec, hr_base;
  logic [6:0]         rv;
  logic [4:0]         h12;
  logic               pm_r;
  logic [7:0]         enc;
  logic               ctl_we;

  for (genvar i = 0; i < FIELD_N; i++) begin : g_hit
    assign hit[i]    = (idx_q == FIELD_ADDR[i]);
    assign ld_sel[i] = dat_we && hit[i];
  end

  // write path: mode-dependent decode into binary 24-hour form
  always_comb begin
    hr12_sel = (idx_q == A_HR) && !h24_q;
    dec_in   = hr12_sel ? {1'b0, wdata[6:0]} : wdata;
    dec      = bin_q ? dec_in : bcd_to_bin(dec_in);
    hr_base  = (dec == 8'd12) ? 8'd0 : dec;
    ld_val   = hr12_sel ? (hr_base + (wdata[7] ? 8'd12 : 8'd0)) : dec;
    ctl_we   = dat_we && (idx_q == A_CTRL);
  end

  // read path: binary 24-hour storage presented in the selected form
  always_comb begin
    h12  = (cur.hr == 5'd0) ? 5'd12 :
           (cur.hr > 5'd12) ? cur.hr - 5'd12 : cur.hr;
    pm_r = (cur.hr >= 5'd12);
    case (idx_q)
      A_SEC:   rv = {1'b0, cur.sec};
      A_MIN:   rv = {1'b0, cur.min};
      A_HR:    rv = h24_q ? {2'b0, cur.hr} : {2'b0, h12};
      A_WDAY:  rv = {4'b0, cur.wday};
      A_MDAY:  rv = {2'b0, cur.mday};
      A_MON:   rv = {3'b0, cur.mon};
      default: rv = cur.yr;
    endcase
    enc = bin_q ? {1'b0, rv} : bin_to_bcd(rv);
    if (idx_q == A_HR && !h24_q) enc[7] = pm_r;
    if (|hit)                    rdata = enc;
    else if (idx_q == A_STAT)    rdata = {uip, 7'd0};
    else if (idx_q == A_CTRL)    rdata = {frz_q, 4'd0, bin_q, h24_q, 1'b0};
    else if (idx_q == A_PWR)     rdata = {vrt, 7'd0};
    else                         rdata = 8'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_we) begin
      idx_q <= wdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_q <= 1'b0;
      bin_q <= 1'b0;
      h24_q <= 1'b0;
    end else if (ctl_we) begin
      frz_q <= wdata[7];
      bin_q <= wdata[2];
      h24_q <= wdata[1];
    end
  end

  assign freeze = frz_q;

endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
  import cal_pkg::*;
#(
  parameter int DIV  = 32768,
  parameter int LEAD = 8,
  parameter int HOLD = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       pwr_ok,
  input  logic       idx_we,
  input  logic       dat_we,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  logic               rst_meta_q, rst_sync_n;
  logic               adv, uip, freeze, vrt_q;
  logic [FIELD_N-1:0] ld_sel;
  logic [7:0]         ld_val;
  cal_time_t          cur_time;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vrt_q <= 1'b1;
    end else if (!pwr_ok) begin
      vrt_q <= 1'b0;
    end
  end

  cal_prescaler #(.DIV(DIV), .LEAD(LEAD), .HOLD(HOLD)) u_pre (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick_32k),
    .freeze (freeze),
    .adv    (adv),
    .uip    (uip)
  );

  cal_time_regs u_time (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .adv    (adv),
    .ld_sel (ld_sel),
    .ld_val (ld_val),
    .cur    (cur_time)
  );

  cal_host_port u_host (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .idx_we (idx_we),
    .dat_we (dat_we),
    .wdata  (wdata),
    .cur    (cur_time),
    .uip    (uip),
    .vrt    (vrt_q),
    .rdata  (rdata),
    .freeze (freeze),
    .ld_sel (ld_sel),
    .ld_val (ld_val)
  );

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
  import cal_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               freeze,
  input logic               uip,
  input logic               adv,
  input logic               vrt,
  input logic               pwr_ok,
  input logic [FIELD_N-1:0] ld_sel,
  input cal_time_t          cur
);

  // R8
  uip_before_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.sec != $past(cur.sec) && !$past(|ld_sel)) |-> $past(uip));

  // R9
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !(|ld_sel)) |=> $stable(cur));

  // R9
  frozen_flag_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !uip);

  // R5
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !(|ld_sel)) |=> (cur.sec < 6'd60));

  // R7
  wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !(|ld_sel) && cur.wday != 3'd0) |=> (cur.wday != 3'd0));

  // R11
  pwr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !vrt);

  // R11
  pwr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vrt |=> !vrt);

endmodule

bind cal_clock_core cal_clock_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .freeze (freeze),
  .uip    (uip),
  .adv    (adv),
  .vrt    (vrt_q),
  .pwr_ok (pwr_ok),
  .ld_sel (ld_sel),
  .cur    (cur_time)
);

// File: tb/sim_cal_clock_core.sv
`timescale 1ns/1ps
module sim_cal_clock_core;
  localparam int DIV  = 8;
  localparam int LEAD = 2;
  localparam int HOLD = 2;
  localparam int NV   = 14;

  // {write ctrl, addr, write value, read ctrl, expected read}
  localparam logic [39:0] VEC [NV] = '{
    {8'h02, 8'h04, 8'h15, 8'h00, 8'h83},
    {8'h02, 8'h04, 8'h00, 8'h00, 8'h12},
    {8'h02, 8'h04, 8'h12, 8'h00, 8'h92},
    {8'h06, 8'h04, 8'h17, 8'h02, 8'h23},
    {8'h00, 8'h04, 8'h92, 8'h06, 8'h0C},
    {8'h00, 8'h04, 8'h12, 8'h06, 8'h00},
    {8'h04, 8'h04, 8'h8B, 8'h02, 8'h23},
    {8'h04, 8'h00, 8'h2D, 8'h00, 8'h45},
    {8'h00, 8'h02, 8'h37, 8'h04, 8'h25},
    {8'h00, 8'h09, 8'h99, 8'h04, 8'h63},
    {8'h04, 8'h07, 8'h1F, 8'h00, 8'h31},
    {8'h00, 8'h08, 8'h12, 8'h04, 8'h0C},
    {8'h00, 8'h06, 8'h07, 8'h04, 8'h07},
    {8'h06, 8'h04, 8'h0C, 8'h04, 8'h8C}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic       pwr_ok = 1'b1;
  logic       idx_we = 1'b0;
  logic       dat_we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  int ph_model = 0;
  logic [7:0] rd;

  always #2.5 clk = ~clk;

  cal_clock_core #(.DIV(DIV), .LEAD(LEAD), .HOLD(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .pwr_ok(pwr_ok),
    .idx_we(idx_we), .dat_we(dat_we), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); idx_we = 1'b1; wdata = a;
    @(negedge clk); idx_we = 1'b0; dat_we = 1'b1; wdata = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); idx_we = 1'b1; wdata = a;
    @(negedge clk); idx_we = 1'b0;
    #1 v = rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_32k = 1'b1;
      @(negedge clk); tick_32k = 1'b0;
      ph_model = (ph_model + 1) % DIV;
    end
  endtask

  task automatic run_to_update();
    do tick(1); while (ph_model != 0);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                          input logic [7:0] wd, input logic [7:0] md,
                          input logic [7:0] mo, input logic [7:0] y);
    wr_reg(8'd0, s); wr_reg(8'd2, m); wr_reg(8'd4, h); wr_reg(8'd6, wd);
    wr_reg(8'd7, md); wr_reg(8'd8, mo); wr_reg(8'd9, y);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_reg(8'd0, rd);  chk("R1 sec", rd, 8'h00);
    rd_reg(8'd4, rd);  chk("R1 hour", rd, 8'h12);
    rd_reg(8'd6, rd);  chk("R1 wday", rd, 8'h01);
    rd_reg(8'd7, rd);  chk("R1 mday", rd, 8'h01);
    rd_reg(8'd8, rd);  chk("R1 month", rd, 8'h01);
    rd_reg(8'd9, rd);  chk("R1 year", rd, 8'h00);
    rd_reg(8'd11, rd); chk("R1 ctrl", rd, 8'h00);
    rd_reg(8'd10, rd); chk("R1 status", rd, 8'h00);
    rd_reg(8'd13, rd); chk("R1 power", rd, 8'h80);

    // R2 index bit 7 ignored, unmapped address reads zero
    @(negedge clk); idx_we = 1'b1; wdata = 8'h82;
    @(negedge clk); idx_we = 1'b0; dat_we = 1'b1; wdata = 8'h33;
    @(negedge clk); dat_we = 1'b0;
    rd_reg(8'd2, rd);  chk("R2 index bit7", rd, 8'h33);
    rd_reg(8'd3, rd);  chk("R2 unmapped", rd, 8'h00);

    // R3 R4 format table
    for (int i = 0; i < NV; i++) begin
      wr_reg(8'd11, VEC[i][39:32]);
      wr_reg(VEC[i][31:24], VEC[i][23:16]);
      wr_reg(8'd11, VEC[i][15:8]);
      rd_reg(VEC[i][31:24], rd);
      chk($sformatf("R3 R4 vector %0d", i), rd, VEC[i][7:0]);
    end

    // R8 status register not writable
    wr_reg(8'd10, 8'hFF);
    rd_reg(8'd10, rd); chk("R8 write ignored", rd, 8'h00);

    wr_reg(8'd11, 8'h02);

    // R5 R10 BCD digit carry from written value
    set_time(8'h10, 8'h20, 8'h09, 8'h03, 8'h15, 8'h06, 8'h23);
    run_to_update();
    rd_reg(8'd0, rd); chk("R10 sec from written", rd, 8'h10);
    rd_reg(8'd2, rd); chk("R5 minute held", rd, 8'h20);

    // R5 minute into hour
    set_time(8'h10, 8'h59, 8'h59, 8'h03, 8'h15, 8'h06, 8'h23);
    run_to_update();
    rd_reg(8'd4, rd); chk("R5 hour carry", rd, 8'h11);
    rd_reg(8'd2, rd); chk("R5 minute wrap", rd, 8'h00);

    // R6 R7 Feb 28 non-leap, weekday 7
    set_time(8'h23, 8'h59, 8'h59, 8'h07, 8'h28, 8'h02, 8'h23);
    run_to_update();
    rd_reg(8'd0, rd); chk("R5 sec wrap", rd, 8'h00);
    rd_reg(8'd4, rd); chk("R5 hour wrap", rd, 8'h00);
    rd_reg(8'd6, rd); chk("R7 weekday wrap", rd, 8'h01);
    rd_reg(8'd7, rd); chk("R6 feb non-leap day", rd, 8'h01);
    rd_reg(8'd8, rd); chk("R6 feb non-leap month", rd, 8'h03);

    // R6 leap February
    set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h28, 8'h02, 8'h24);
    run_to_update();
    rd_reg(8'd7, rd); chk("R6 leap day 29", rd, 8'h29);
    rd_reg(8'd8, rd); chk("R6 leap month", rd, 8'h02);
    rd_reg(8'd6, rd); chk("R7 weekday step", rd, 8'h03);
    set_time(8'h23, 8'h59, 8'h59, 8'h03, 8'h29, 8'h02, 8'h24);
    run_to_update();
    rd_reg(8'd7, rd); chk("R6 leap end day", rd, 8'h01);
    rd_reg(8'd8, rd); chk("R6 leap end month", rd, 8'h03);

    // R6 thirty-day month
    set_time(8'h23, 8'h59, 8'h59, 8'h04, 8'h30, 8'h04, 8'h23);
    run_to_update();
    rd_reg(8'd7, rd); chk("R6 april day", rd, 8'h01);
    rd_reg(8'd8, rd); chk("R6 april month", rd, 8'h05);

    // R7 year wrap
    set_time(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
    run_to_update();
    rd_reg(8'd9, rd); chk("R7 year wrap", rd, 8'h00);
    rd_reg(8'd8, rd); chk("R7 month wrap", rd, 8'h01);
    rd_reg(8'd7, rd); chk("R7 day after dec", rd, 8'h01);

    // R8 flag window
    run_to_update();
    tick(2); rd_reg(8'd10, rd); chk("R8 low after hold", rd, 8'h00);
    tick(3); rd_reg(8'd10, rd); chk("R8 low before lead", rd, 8'h00);
    tick(1); rd_reg(8'd10, rd); chk("R8 rise at lead", rd, 8'h80);
    tick(1); rd_reg(8'd10, rd); chk("R8 high before update", rd, 8'h80);
    tick(1); rd_reg(8'd10, rd); chk("R8 high at update", rd, 8'h80);
    tick(1); rd_reg(8'd10, rd); chk("R8 high in hold", rd, 8'h80);
    tick(1); rd_reg(8'd10, rd); chk("R8 fall after hold", rd, 8'h00);

    // R9 freeze
    wr_reg(8'd11, 8'h82);
    wr_reg(8'd0, 8'h10);
    while (ph_model != 6) tick(1);
    rd_reg(8'd10, rd); chk("R9 flag low frozen", rd, 8'h00);
    run_to_update();
    rd_reg(8'd0, rd);  chk("R9 no update frozen", rd, 8'h10);
    wr_reg(8'd11, 8'h02);
    run_to_update();
    rd_reg(8'd0, rd);  chk("R9 resume", rd, 8'h11);

    // R11 power flag
    @(negedge clk); pwr_ok = 1'b0;
    @(negedge clk); pwr_ok = 1'b1;
    rd_reg(8'd13, rd); chk("R11 power dropped", rd, 8'h00);
    repeat (3) @(negedge clk);
    rd_reg(8'd13, rd); chk("R11 power sticky", rd, 8'h00);

    summary();
    $finish;
  end

endmodule